// File: doc/BRIEF.md
# Floating-Point Audio Word to Linear Sample Converter

This block turns a compressed audio word into a 16-bit linear sample. The 13-bit input word carries a 3-bit exponent and a 10-bit two's-complement mantissa. Each word arrives with a one-cycle valid strobe. The block scales the mantissa by a power of two chosen by the exponent and registers the result. It raises an output strobe one clock later and holds the sample until the next word.

Two static configuration inputs adapt the block to its neighbours. The first makes the block complement the exponent field before using it, for sources that send the exponent inverted. The second selects the output format: two's-complement, or offset binary with silence at mid-scale.

Top module: `fp2lin`

## Requirements
- R1: The mantissa is taken from bits 9:0 of the input word as a two's-complement value. The exponent field is taken from bits 12:10.
- R2: When `cfg_exp_inv` is 1, the effective exponent is the bitwise complement of the 3-bit field. When it is 0, the effective exponent is the field unchanged.
- R3: An effective exponent of 0 gives a signed result of zero. This appears as 0x0000 in signed mode and as 0x8000 in offset-binary mode.
- R4: For an effective exponent e from 1 to 7, the signed result is the mantissa shifted left by e-1. When mantissa bit 9 is 1, every result bit above position e+8 is 1.
- R5: When `cfg_unsigned` is 1, the output is the signed result plus 32768, modulo 2^16.
- R6: `out_valid` is high for exactly one cycle, one clock after each cycle in which `in_valid` is high. It is low otherwise.
- R7: `out_sample` keeps its value in every cycle that follows a cycle with `in_valid` low.
- R8: With an effective exponent of 7, mantissa -512 gives exactly 0x8000 and mantissa 511 gives 0x7FC0 in signed mode, with no wrap.
- R9: After reset, `out_valid` is 0 and `out_sample` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 13 | Exponent in bits 12:10, mantissa in bits 9:0 |
| cfg_exp_inv | input | 1 | 1 = complement the exponent field before use |
| cfg_unsigned | input | 1 | 1 = offset-binary output, 0 = two's-complement |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Linear sample |

## Verification
The bench sweeps every one of the 8192 input words under all four settings of the two configuration inputs. This covers each effective exponent and each mantissa sign, including the zero exponent. A design that shifted by e instead of e-1 would wrap at exponent 7 and turn -512 into a wrong sign. A design that dropped the sign fill would make negative samples large and positive. A design that ignored the inversion input would swap loud and quiet words. A design that applied the offset to the zero-exponent case incorrectly would produce a full-scale click instead of mid-scale silence. Between strobes the bench changes the input word with the strobe low and confirms that the output holds and that the output strobe stays a single pulse.

// File: rtl/fp2lin.sv
module fp2lin #(
  parameter int MANT_W = 10,
  parameter int EXP_W  = 3,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [MANT_W+EXP_W-1:0] in_word,
  input  logic                    cfg_exp_inv,
  input  logic                    cfg_unsigned,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_sample
);
  localparam int IN_W = MANT_W + EXP_W;

  logic [EXP_W-1:0]  exp_raw, exp_eff, shamt;
  logic [MANT_W-1:0] mant;
  logic [OUT_W-1:0]  mant_ext, scaled, lin, fmt;

  assign exp_raw  = in_word[IN_W-1:MANT_W];
  assign mant     = in_word[MANT_W-1:0];
  assign exp_eff  = cfg_exp_inv ? ~exp_raw : exp_raw;
  assign shamt    = exp_eff - EXP_W'(1);
  assign mant_ext = {{(OUT_W-MANT_W){mant[MANT_W-1]}}, mant};
  assign scaled   = mant_ext << shamt;
  assign lin      = (exp_eff == '0) ? '0 : scaled;
  assign fmt      = cfg_unsigned ? {~lin[OUT_W-1], lin[OUT_W-2:0]} : lin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= fmt;
    end
  end
endmodule

// File: rtl/fp2lin_chk.sv
module fp2lin_chk #(
  parameter int MANT_W = 10,
  parameter int EXP_W  = 3,
  parameter int OUT_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [MANT_W+EXP_W-1:0] in_word,
  input logic                    cfg_exp_inv,
  input logic                    cfg_unsigned,
  input logic                    out_valid,
  input logic [OUT_W-1:0]        out_sample
);
  logic [EXP_W-1:0] e_chk;
  assign e_chk = in_word[MANT_W+EXP_W-1:MANT_W] ^ {EXP_W{cfg_exp_inv}};

  // R6
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R6
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));
  // R3
  zero_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && e_chk == '0 && !cfg_unsigned) |=> out_sample == '0);
  // R3
  zero_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && e_chk == '0 && cfg_unsigned) |=> out_sample == {1'b1, {(OUT_W-1){1'b0}}});
  // R4
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && e_chk != '0 && !cfg_unsigned) |=> out_sample[OUT_W-1] == $past(in_word[MANT_W-1]));
endmodule

bind fp2lin fp2lin_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .cfg_exp_inv(cfg_exp_inv), .cfg_unsigned(cfg_unsigned),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/fp2lin_tb_top.sv
`timescale 1ns/1ps
module fp2lin_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [12:0] in_word = '0;
  logic        cfg_exp_inv = 1'b0;
  logic        cfg_unsigned = 1'b0;
  logic        out_valid;
  logic [15:0] out_sample;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fp2lin dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .cfg_exp_inv(cfg_exp_inv), .cfg_unsigned(cfg_unsigned),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic logic [15:0] model(input logic [12:0] w, input bit inv, input bit uns);
    int e, m, s;
    e = int'(w[12:10]);
    if (inv) e = 7 - e;
    m = int'(w[9:0]);
    if (m >= 512) m = m - 1024;
    s = (e == 0) ? 0 : m * (1 << (e - 1));
    if (uns) s = s + 32768;
    return 16'(s);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (word=%h inv=%0b uns=%0b)",
               tag, act, exp_v, in_word, cfg_exp_inv, cfg_unsigned);
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 valid", {15'd0, out_valid}, 16'd0);
    check("R9 sample", out_sample, 16'd0);
    for (int cfg = 0; cfg < 4; cfg++) begin
      cfg_exp_inv  = cfg[0];
      cfg_unsigned = cfg[1];
      for (int w = 0; w < 8192; w++) begin
        logic [15:0] exp_v;
        string tag;
        int e;
        in_word  = 13'(w);
        in_valid = 1'b1;
        exp_v = model(in_word, cfg_exp_inv, cfg_unsigned);
        e = cfg_exp_inv ? 7 - (w >> 10) : (w >> 10);
        if (e == 0) tag = "R3 zero exponent";
        else if (e == 7 && !cfg_unsigned && (w[9:0] == 10'h200 || w[9:0] == 10'h1FF)) tag = "R8 full scale";
        else if (cfg_unsigned) tag = "R5 offset binary";
        else if (cfg_exp_inv) tag = "R2 inverted exponent";
        else tag = "R4 R1 shift and sign";
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = ~in_word;
        check(tag, out_sample, exp_v);
        check("R6 strobe high", {15'd0, out_valid}, 16'd1);
        @(negedge clk);
        // R7 hold with changed input and strobe low
        check("R7 hold", out_sample, exp_v);
        check("R6 strobe low", {15'd0, out_valid}, 16'd0);
      end
    end
    // R8 explicit full-scale points, signed, no inversion
    cfg_exp_inv = 1'b0; cfg_unsigned = 1'b0;
    in_word = {3'd7, 10'h200}; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R8 negative full scale", out_sample, 16'h8000);
    in_word = {3'd7, 10'h1FF}; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R8 positive full scale", out_sample, 16'h7FC0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule